// File: doc/BRIEF.md
# Programmable IR Pulse Timing Generator

This block drives an infrared emitter from a reference clock that is nominally 3.6864 MHz. A single baud prescaler, set by software, divides the clock into a tick. Two counts measured in that tick set the length of each pulse period and the length of the active part at the start of the period. A much slower unit, about 7.8 ms and set by the `SLOW_DIV` parameter, times two intervals. The delay interval comes first and runs once after enable. The wait interval separates later pulses, and its length is a multiple of the delay interval.

Software reaches the block through one write port that carries a register select. Select 0 holds the prescaler, the output invert bit and two enable bits. Select 1 holds the four 8-bit timing fields. Writes to the timing fields made while a pulse is being emitted are held back until that pulse ends. The `phase` output shows which part of the sequence is running.

Top module: `ir_pulse_gen`

## Requirements
- R1: After reset, `phase` is 0, `irOut` is 0 and both enable bits are clear.
- R2: A pulsing phase lasts (PER+1)×(BAUD+1) clock cycles. PER is `wrData[31:24]` written with `wrSel`=1. BAUD is `wrData[23:16]` written with `wrSel`=0.
- R3: `irOut` is active (1 when not inverted) for the first ON×(BAUD+1) cycles of each period and inactive for the rest. ON is `wrData[23:16]` written with `wrSel`=1.
- R4: When ON is 0, `irOut` stays inactive for the whole period.
- R5: When ON is greater than PER, `irOut` stays active for the whole period.
- R6: The delay phase lasts (DLY+1)×`SLOW_DIV` cycles. DLY is `wrData[15:8]` written with `wrSel`=1.
- R7: The wait phase lasts (DLY+1)×(WT+1)×`SLOW_DIV` cycles. WT is `wrData[7:0]` written with `wrSel`=1.
- R8: `phase` encodes 0 = idle, 1 = delay, 2 = pulsing and 3 = wait. While the block is enabled, the phases run in the order idle, delay, pulsing, wait, pulsing, wait, and so on. Each pulsing phase is one period.
- R9: Writing `wrData[3]`=1 with `wrSel`=0 inverts `irOut`, in every phase including idle.
- R10: The block runs only when both enable bits are set: `wrData[0]` and `wrData[1]`, written with `wrSel`=0. One clock after either bit is cleared, `phase` is 0.
- R11: A timing write made during a pulsing phase does not change that pulse. The new values apply from the next period onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 = mode/prescaler register, 1 = timing register |
| wrData | input | 32 | Write data |
| irOut | output | 1 | IR drive output |
| phase | output | 2 | Current sequence phase |

## Verification
The embedded assertions check several properties on every cycle:
- the phase falls to idle after the block is disabled;
- each phase moves only to its legal successor;
- the applied timing set is frozen during a pulse;
- the period and unit counters stay in range;
- `irOut` sits at its inactive level outside the pulsing phase and when ON is 0.

Interval lengths, the on-time count inside a period and the deferred take-up of a mid-pulse timing write can only be shown by the bench. It measures the length of each phase and counts the active cycles in it, then compares both against values computed from the formulas.

// File: rtl/ir_pulse_pkg.sv
package ir_pulse_pkg;

  localparam int FW = 8;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_PULSE = 2'd2,
    PH_WAIT  = 2'd3
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;      // phase changes at the next edge
    logic inPulse;     // pulsing phase
    logic inTimed;     // delay or wait phase
    logic inWait;      // wait phase
    logic holdTiming;  // freeze applied timing set
  } strobe_t;

  typedef struct packed {
    logic [FW-1:0] per;
    logic [FW-1:0] onTime;
    logic [FW-1:0] dly;
    logic [FW-1:0] wt;
    logic [FW-1:0] baud;
  } timing_t;

endpackage

// File: rtl/ir_pulse_ctrl.sv
module ir_pulse_ctrl
  import ir_pulse_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enabled,
  input  logic    periodEnd,
  input  logic    delayDone,
  input  logic    waitDone,
  output phase_t  phase,
  output strobe_t stb
);

  phase_t nxt;

  always_comb begin
    nxt = phase;
    if (!enabled) begin
      nxt = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE:  nxt = PH_DELAY;
        PH_DELAY: if (delayDone) nxt = PH_PULSE;
        PH_PULSE: if (periodEnd) nxt = PH_WAIT;
        PH_WAIT:  if (waitDone)  nxt = PH_PULSE;
        default:  nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= nxt;
  end

  always_comb begin
    stb.clrCnt     = (nxt != phase);
    stb.inPulse    = (phase == PH_PULSE);
    stb.inTimed    = (phase == PH_DELAY) || (phase == PH_WAIT);
    stb.inWait     = (phase == PH_WAIT);
    stb.holdTiming = (phase == PH_PULSE);
  end

  // R10: disabling forces idle one clock later
  p_off_to_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |=> phase == PH_IDLE);

  // R8: legal successors
  p_idle_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_IDLE |=> (phase == PH_IDLE || phase == PH_DELAY));
  p_delay_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_DELAY |=> (phase != PH_WAIT));
  p_pulse_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_PULSE |=> (phase != PH_DELAY));
  p_wait_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_WAIT |=> (phase != PH_DELAY));

endmodule

// File: rtl/ir_pulse_dp.sv
module ir_pulse_dp
  import ir_pulse_pkg::*;
#(
  parameter int SLOW_DIV = 28800
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [31:0] wrData,
  input  strobe_t     stb,
  output logic        enabled,
  output logic        periodEnd,
  output logic        delayDone,
  output logic        waitDone,
  output logic        irOut
);

  localparam int SW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);
  localparam int UW = 2 * FW;

  logic          cfgInv, cfgSm, cfgSt;
  logic [FW-1:0] cfgBaud;
  logic [FW-1:0] pendPer, pendOn, pendDly, pendWt;
  timing_t       act;

  logic [FW-1:0] baudCnt, perCnt;
  logic [SW-1:0] slowCnt;
  logic [UW-1:0] unitCnt;
  logic [UW:0]   waitProd;
  logic [UW-1:0] waitLast;
  logic          tick, slowTick, pulseOn;
  logic          unusedCfgBits;

  assign unusedCfgBits = ^{wrData[31:24], wrData[15:4], wrData[2]};

  // register write port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgBaud <= '0; cfgInv <= 1'b0; cfgSm <= 1'b0; cfgSt <= 1'b0;
      pendPer <= '0; pendOn <= '0; pendDly <= '0; pendWt <= '0;
    end else if (wrEn) begin
      if (!wrSel) begin
        cfgBaud <= wrData[23:16];
        cfgInv  <= wrData[3];
        cfgSt   <= wrData[1];
        cfgSm   <= wrData[0];
      end else begin
        pendPer <= wrData[31:24];
        pendOn  <= wrData[23:16];
        pendDly <= wrData[15:8];
        pendWt  <= wrData[7:0];
      end
    end
  end

  // applied timing set, frozen while a pulse runs
  always_ff @(posedge clk) begin
    if (!rstN)                act <= '0;
    else if (!stb.holdTiming) act <= '{per: pendPer, onTime: pendOn, dly: pendDly,
                                       wt: pendWt, baud: cfgBaud};
  end

  assign enabled = cfgSm & cfgSt;

  // baud prescaler and period counter
  assign tick      = stb.inPulse && (baudCnt == act.baud);
  assign periodEnd = tick && (perCnt == act.per);

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrCnt || !stb.inPulse) begin
      baudCnt <= '0;
      perCnt  <= '0;
    end else begin
      baudCnt <= tick ? '0 : baudCnt + 1'b1;
      if (tick) perCnt <= (perCnt == act.per) ? '0 : perCnt + 1'b1;
    end
  end

  assign pulseOn = stb.inPulse && (perCnt < act.onTime);
  assign irOut   = pulseOn ^ cfgInv;

  // slow timebase and unit counter
  assign slowTick = stb.inTimed && (slowCnt == SLOW_LAST);
  assign waitProd = ({{(UW+1-FW){1'b0}}, act.dly} + 1'b1) *
                    ({{(UW+1-FW){1'b0}}, act.wt} + 1'b1);
  assign waitLast = UW'(waitProd - 1'b1);
  assign delayDone = slowTick && !stb.inWait && (unitCnt == {{(UW-FW){1'b0}}, act.dly});
  assign waitDone  = slowTick &&  stb.inWait && (unitCnt == waitLast);

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrCnt || !stb.inTimed) begin
      slowCnt <= '0;
      unitCnt <= '0;
    end else begin
      slowCnt <= slowTick ? '0 : slowCnt + 1'b1;
      if (slowTick) unitCnt <= unitCnt + 1'b1;
    end
  end

  // R11: applied timing cannot move during a pulse
  p_hold_timing_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.holdTiming |=> $stable(act));
  // R2: period counter never passes its limit
  p_per_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.inPulse |-> perCnt <= act.per);
  // R9: inactive level outside pulsing
  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.inPulse |-> irOut == cfgInv);
  // R4: zero on-time keeps output inactive
  p_zero_on_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inPulse && act.onTime == '0) |-> irOut == cfgInv);
  // R7: unit counter bounded by the wait length
  p_unit_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.inWait |-> unitCnt <= waitLast);

endmodule

// File: rtl/ir_pulse_gen.sv
module ir_pulse_gen
  import ir_pulse_pkg::*;
#(
  parameter int SLOW_DIV = 28800
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [31:0] wrData,
  output logic        irOut,
  output logic [1:0]  phase
);

  strobe_t stb;
  phase_t  ph;
  logic    enabled, periodEnd, delayDone, waitDone;

  ir_pulse_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .enabled(enabled), .periodEnd(periodEnd),
    .delayDone(delayDone), .waitDone(waitDone), .phase(ph), .stb(stb)
  );

  ir_pulse_dp #(.SLOW_DIV(SLOW_DIV)) i_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .stb(stb), .enabled(enabled), .periodEnd(periodEnd),
    .delayDone(delayDone), .waitDone(waitDone), .irOut(irOut)
  );

  assign phase = ph;

endmodule

// File: tb/test_ir_pulse_gen.sv
module test_ir_pulse_gen;

  localparam int SLOW = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic        irOut;
  logic [1:0]  phase;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    int    ph;
    int    len;
    int    highs;
    string tag;
  } item_t;
  item_t q[$];

  ir_pulse_gen #(.SLOW_DIV(SLOW)) i_ir_pulse_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .irOut(irOut), .phase(phase)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [31:0] modeWord(input logic [7:0] baud, input bit inv,
                                           input bit st, input bit sm);
    return {8'h00, baud, 12'h000, inv, 1'b0, st, sm};
  endfunction

  function automatic logic [31:0] timeWord(input logic [7:0] per, input logic [7:0] on,
                                           input logic [7:0] dly, input logic [7:0] wt);
    return {per, on, dly, wt};
  endfunction

  task automatic expect_seg(input int ph, input int len, input int hi, input string tag);
    item_t it;
    it.ph = ph; it.len = len; it.highs = hi; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor: measures each phase segment and compares with the scoreboard
  int curPh = 0;
  int runLen = 0;
  int runHi = 0;
  always @(negedge clk) begin : monitor
    item_t e;
    if (rstN) begin
      if (int'(phase) != curPh) begin
        if (curPh != 0 && phase != 2'd0 && q.size() > 0) begin
          e = q.pop_front();
          check(e.ph == curPh, {e.tag, " R8 phase"}, curPh, e.ph);
          check(e.len == runLen, {e.tag, " length"}, runLen, e.len);
          check(e.highs == runHi, {e.tag, " active cycles"}, runHi, e.highs);
        end
        curPh  = int'(phase);
        runLen = 1;
        runHi  = int'(irOut);
      end else begin
        runLen++;
        runHi += int'(irOut);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(phase == 2'd0, "R1 phase", int'(phase), 0);
    check(irOut == 1'b0, "R1 irOut", int'(irOut), 0);

    // R10: only one enable bit set -> stays idle
    wr(1'b0, modeWord(8'd2, 1'b0, 1'b0, 1'b1));
    repeat (30) @(negedge clk);
    check(phase == 2'd0, "R10 machine enable alone", int'(phase), 0);
    wr(1'b0, modeWord(8'd2, 1'b0, 1'b1, 1'b0));
    repeat (30) @(negedge clk);
    check(phase == 2'd0, "R10 state enable alone", int'(phase), 0);

    // Scenario 1: R2 R3 R6 R7 R8
    wr(1'b1, timeWord(8'd4, 8'd2, 8'd1, 8'd1));
    expect_seg(1, 2*SLOW, 0, "R6");
    expect_seg(2, 15, 6, "R2/R3");
    expect_seg(3, 4*SLOW, 0, "R7");
    expect_seg(2, 15, 6, "R8 second pulse");
    expect_seg(3, 4*SLOW, 0, "R7 second wait");
    wr(1'b0, modeWord(8'd2, 1'b0, 1'b1, 1'b1));
    drain();
    wr(1'b0, modeWord(8'd2, 1'b0, 1'b1, 1'b0));
    @(negedge clk);
    check(phase == 2'd0, "R10 disable to idle", int'(phase), 0);

    // Scenario 2: R4 zero on-time
    wr(1'b1, timeWord(8'd3, 8'd0, 8'd0, 8'd2));
    expect_seg(1, SLOW, 0, "R6 single unit");
    expect_seg(2, 8, 0, "R4");
    expect_seg(3, 3*SLOW, 0, "R7 wait x3");
    expect_seg(2, 8, 0, "R4 again");
    wr(1'b0, modeWord(8'd1, 1'b0, 1'b1, 1'b1));
    drain();
    wr(1'b0, modeWord(8'd1, 1'b0, 1'b0, 1'b1));
    @(negedge clk);
    check(phase == 2'd0, "R10 second disable", int'(phase), 0);

    // Scenario 3: R5 on-time beyond period, R9 inverted
    wr(1'b1, timeWord(8'd3, 8'd9, 8'd0, 8'd0));
    expect_seg(1, SLOW, SLOW, "R6/R9");
    expect_seg(2, 8, 0, "R5/R9");
    expect_seg(3, SLOW, SLOW, "R7/R9");
    wr(1'b0, modeWord(8'd1, 1'b1, 1'b1, 1'b1));
    drain();
    wr(1'b0, modeWord(8'd1, 1'b1, 1'b0, 1'b0));
    @(negedge clk);
    check(phase == 2'd0, "R10 third disable", int'(phase), 0);
    check(irOut == 1'b1, "R9 idle inverted", int'(irOut), 1);

    // Scenario 4: R11 timing write during a pulse
    wr(1'b1, timeWord(8'd9, 8'd5, 8'd0, 8'd0));
    expect_seg(1, SLOW, 0, "R6 before update");
    expect_seg(2, 10, 5, "R11 current pulse kept");
    expect_seg(3, SLOW, 0, "R7 after update");
    expect_seg(2, 4, 1, "R11 new period");
    wr(1'b0, modeWord(8'd0, 1'b0, 1'b1, 1'b1));
    while (phase != 2'd2) @(negedge clk);
    wr(1'b1, timeWord(8'd3, 8'd1, 8'd0, 8'd0));
    drain();
    wr(1'b0, modeWord(8'd0, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    check(phase == 2'd0, "R10 final disable", int'(phase), 0);
    check(irOut == 1'b0, "R9 idle not inverted", int'(irOut), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule